// File: doc/BRIEF.md
# Radio SPI command sequencer

This block is an SPI master that sends framed command transactions to an external long-range radio transceiver. A client hands it one request at a time. Each request carries a kind, an opcode, a 16-bit address and a byte count. Parameter bytes for write-type frames arrive on a byte stream with a valid/ready handshake. Bytes read back leave on a pulsed output.

Before it lowers chip select, the sequencer waits while the transceiver's BUSY line is high. The wait is bounded. If BUSY is still high when the limit runs out, the transaction goes ahead anyway and is flagged as timed out. The frame layout depends on the kind: address bytes, a status slot or a dummy byte are inserted as each command requires. For buffer writes the block keeps its own transmit offset pointer.

The SCLK half-period is the parameter `HALF_DIV`, counted in system clocks. With a 64 MHz system clock the default of 4 gives an 8 MHz SCLK. `BUSY_TIMEOUT` counts the busy-wait limit in system clocks. Its default of 6,400,000 gives 100 ms at 64 MHz.

Top module: `radio_cmd_spi`

## Requirements
- R1: After reset, `req_ready` is 1, `spi_cs_n` is 1, `spi_sclk` is 0 and `tx_ptr` is 0. `req_ready` is 1 only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and `req_ready` is 0 from then until the transaction ends.
- R2: While `radio_busy` is 1, chip select stays high. If BUSY has not dropped after `BUSY_TIMEOUT` clocks of waiting, chip select is lowered and the frame is sent anyway.
- R3: SPI mode 0, MSB first. SCLK idles low. MOSI changes only while SCLK is low. MISO is sampled on the rising SCLK edge.
- R4: Chip select stays low for the whole frame, with at least one SCLK half-period before the first SCLK edge and after the last one. `done` pulses for one clock in the cycle in which chip select returns high.
- R5: Kind 0 (opcode write) sends the opcode, then `req_count` bytes taken from the write stream.
- R6: Kind 1 (opcode read) sends the opcode and a 0x00 status slot whose MISO byte is discarded. It then sends `req_count` bytes of 0x00 and returns each MISO byte on `rd_data` with `rd_valid`.
- R7: Kind 2 (register read) sends 0x1D, address high byte, address low byte, one 0x00 dummy and one final 0x00. Only the MISO byte of the final transfer is returned, as exactly one `rd_valid` pulse. `req_count` is ignored.
- R8: Kind 3 (register write) sends 0x0D, address high byte, address low byte, then one byte from the write stream. `req_count` is ignored.
- R9: Kind 4 (buffer write) sends 0x0E, a one-byte offset equal to the transmit pointer, then `req_count` stream bytes. If `req_addr[15]` is 1, the pointer is first loaded from `req_addr[7:0]`. The pointer advances by one per payload byte, wraps modulo 256, and is visible on `tx_ptr`.
- R10: Kind 5 (buffer read) sends 0x1E, `req_addr[7:0]`, one 0x00 dummy, then `req_count` bytes of 0x00. The MISO bytes of those last transfers are returned.
- R11: If a write-stream byte is needed but `wr_valid` is 0, SCLK stays low and chip select stays low until a byte is offered.
- R12: `timeout` is 1, together with `done`, only for a transaction whose busy wait ran out. Otherwise `timeout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_kind | input | 3 | Frame kind, codes 0 to 5 (6 and 7 act as 0) |
| req_opcode | input | 8 | Opcode for kinds 0 and 1 |
| req_addr | input | 16 | Register address, buffer offset, pointer reload |
| req_count | input | CNT_W | Payload or response byte count |
| wr_valid | input | 1 | Write-stream byte offered |
| wr_ready | output | 1 | Write-stream byte taken this clock |
| wr_data | input | 8 | Write-stream byte |
| rd_valid | output | 1 | Read byte pulse |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Transaction finished, chip select released |
| timeout | output | 1 | Busy wait expired for this transaction |
| tx_ptr | output | 8 | Buffer-write offset pointer |
| radio_busy | input | 1 | Transceiver BUSY line |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Master out |
| spi_miso | input | 1 | Master in |

## Verification
The bench goes after the framing that differs by kind:
- The status slot of a command read and the dummy byte of register and buffer reads must not reach `rd_data`. A design that returned them would put an extra byte in the read stream, shifted one position early.
- The buffer-write offset must follow the pointer across two frames, with and without a reload. A design that restarted the pointer at zero, or advanced it wrongly, would send a wrong offset byte and show a wrong `tx_ptr`.
- A zero-count command must send only its opcode.

The BUSY handshake is tested twice. A short BUSY pulse must hold chip select high and finish without a timeout. A stuck BUSY must still produce a correct frame, marked as timed out. A late write-stream byte must freeze SCLK with chip select low; a design that did not wait would shift out stale data.

// File: rtl/radio_cmd_spi.sv
module radio_cmd_spi #(
  parameter int HALF_DIV     = 4,
  parameter int BUSY_TIMEOUT = 6_400_000,
  parameter int CNT_W        = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_kind,
  input  logic [7:0]       req_opcode,
  input  logic [15:0]      req_addr,
  input  logic [CNT_W-1:0] req_count,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             timeout,
  output logic [7:0]       tx_ptr,
  input  logic             radio_busy,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int IW = CNT_W + 1;
  localparam int HW = $clog2(HALF_DIV + 1);
  localparam int BW = $clog2(BUSY_TIMEOUT + 1);
  localparam logic [2:0] K_OPR = 3'd1, K_RGR = 3'd2, K_RGW = 3'd3, K_BFW = 3'd4, K_BFR = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_BUSY, S_SETUP, S_LOAD, S_SHIFT, S_HOLD} st_t;

  st_t              st;
  logic [2:0]       kind_q;
  logic [7:0]       op_q;
  logic [15:0]      addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IW-1:0]    idx;
  logic [HW-1:0]    hcnt;
  logic [BW-1:0]    btmr;
  logic [2:0]       bitn;
  logic [7:0]       tx, rx;
  logic             to_flag;

  logic [IW-1:0] hdr_len, body_len, total;
  logic [7:0]    hdr_byte;
  logic          is_rd, in_body, half_end;

  always_comb begin
    case (kind_q)
      K_OPR:   hdr_len = IW'(2);
      K_RGR:   hdr_len = IW'(4);
      K_RGW:   hdr_len = IW'(3);
      K_BFW:   hdr_len = IW'(2);
      K_BFR:   hdr_len = IW'(3);
      default: hdr_len = IW'(1);
    endcase
    case (kind_q)
      K_OPR:   hdr_byte = (idx[1:0] == 2'd0) ? op_q : 8'h00;
      K_RGR:   case (idx[1:0])
                 2'd0:    hdr_byte = 8'h1D;
                 2'd1:    hdr_byte = addr_q[15:8];
                 2'd2:    hdr_byte = addr_q[7:0];
                 default: hdr_byte = 8'h00;
               endcase
      K_RGW:   case (idx[1:0])
                 2'd0:    hdr_byte = 8'h0D;
                 2'd1:    hdr_byte = addr_q[15:8];
                 default: hdr_byte = addr_q[7:0];
               endcase
      K_BFW:   hdr_byte = (idx[1:0] == 2'd0) ? 8'h0E : tx_ptr;
      K_BFR:   case (idx[1:0])
                 2'd0:    hdr_byte = 8'h1E;
                 2'd1:    hdr_byte = addr_q[7:0];
                 default: hdr_byte = 8'h00;
               endcase
      default: hdr_byte = op_q;
    endcase
  end

  assign body_len  = (kind_q == K_RGR || kind_q == K_RGW) ? IW'(1) : IW'(cnt_q);
  assign total     = hdr_len + body_len;
  assign is_rd     = (kind_q == K_OPR) || (kind_q == K_RGR) || (kind_q == K_BFR);
  assign in_body   = idx >= hdr_len;
  assign half_end  = hcnt == HW'(HALF_DIV - 1);
  assign req_ready = st == S_IDLE;
  assign wr_ready  = (st == S_LOAD) && in_body && !is_rd;
  assign spi_mosi  = tx[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      kind_q <= '0; op_q <= '0; addr_q <= '0; cnt_q <= '0;
      idx <= '0; hcnt <= '0; btmr <= '0; bitn <= '0;
      tx <= '0; rx <= '0; to_flag <= 1'b0; tx_ptr <= '0;
      spi_cs_n <= 1'b1; spi_sclk <= 1'b0;
      done <= 1'b0; timeout <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      done <= 1'b0;
      timeout <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          kind_q <= req_kind; op_q <= req_opcode; addr_q <= req_addr; cnt_q <= req_count;
          if (req_kind == K_BFW && req_addr[15]) tx_ptr <= req_addr[7:0];
          idx <= '0; btmr <= '0; to_flag <= 1'b0;
          st <= S_BUSY;
        end
        S_BUSY: begin
          if (!radio_busy || btmr == BW'(BUSY_TIMEOUT - 1)) begin
            to_flag <= radio_busy;
            spi_cs_n <= 1'b0;
            hcnt <= '0;
            st <= S_SETUP;
          end else btmr <= btmr + BW'(1);
        end
        S_SETUP: begin
          hcnt <= hcnt + HW'(1);
          if (half_end) st <= S_LOAD;
        end
        S_LOAD: begin
          hcnt <= '0;
          bitn <= '0;
          if (!in_body) begin
            tx <= hdr_byte; st <= S_SHIFT;
          end else if (is_rd) begin
            tx <= 8'h00; st <= S_SHIFT;
          end else if (wr_valid) begin
            tx <= wr_data; st <= S_SHIFT;
            if (kind_q == K_BFW) tx_ptr <= tx_ptr + 8'd1;
          end
        end
        S_SHIFT: begin
          hcnt <= half_end ? '0 : hcnt + HW'(1);
          if (half_end && !spi_sclk) begin
            spi_sclk <= 1'b1;
            rx <= {rx[6:0], spi_miso};
          end else if (half_end) begin
            spi_sclk <= 1'b0;
            tx <= {tx[6:0], 1'b0};
            bitn <= bitn + 3'd1;
            if (bitn == 3'd7) begin
              rd_valid <= in_body && is_rd;
              rd_data <= rx;
              idx <= idx + IW'(1);
              st <= (idx + IW'(1) == total) ? S_HOLD : S_LOAD;
            end
          end
        end
        S_HOLD: begin
          hcnt <= hcnt + HW'(1);
          if (half_end) begin
            spi_cs_n <= 1'b1;
            done <= 1'b1;
            timeout <= to_flag;
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/radio_cmd_spi_chk.sv
module radio_cmd_spi_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic done,
  input logic timeout,
  input logic rd_valid
);
  assert_ready_only_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> spi_cs_n);
  assert_sclk_low_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  assert_mosi_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));
  assert_done_on_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> done);
  assert_release_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(spi_cs_n));
  assert_read_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !spi_cs_n);
  assert_timeout_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> done);
endmodule

bind radio_cmd_spi radio_cmd_spi_chk u_chk (.*);

// File: tb/sim_radio_cmd_spi.sv
`timescale 1ns/1ps
module sim_radio_cmd_spi;
  localparam int CW = 9;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_kind = '0;
  logic [7:0] req_opcode = '0;
  logic [15:0] req_addr = '0;
  logic [CW-1:0] req_count = '0;
  logic wr_valid = 1'b0, wr_ready;
  logic [7:0] wr_data = '0;
  logic rd_valid, done, timeout;
  logic [7:0] rd_data, tx_ptr;
  logic radio_busy = 1'b0;
  logic spi_cs_n, spi_sclk, spi_mosi;
  logic spi_miso = 1'b0;

  radio_cmd_spi #(.HALF_DIV(2), .BUSY_TIMEOUT(100), .CNT_W(CW)) u0 (.*);

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  string cur_tag = "R1";
  logic [7:0] exp_mosi[$], exp_rd[$], wr_q[$], pay[$];
  logic [7:0] m_ptr = 8'h00;
  bit wr_pend = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int n);
    return 8'hC3 ^ 8'(n * 37);
  endfunction

  // SPI slave model: collects MOSI bytes, drives a position-dependent MISO pattern
  int sb_bit = 0, sb_pos = 0;
  logic [7:0] sb_shift = '0;
  always @(negedge spi_cs_n) begin
    sb_bit = 0; sb_pos = 0;
    spi_miso = pat(0) >> 7;
  end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    sb_shift = {sb_shift[6:0], spi_mosi};
    sb_bit++;
    if (sb_bit == 8) begin
      if (exp_mosi.size() == 0) chk(1'b0, {cur_tag, " extra mosi byte"}, sb_shift, 0);
      else begin
        logic [7:0] e;
        e = exp_mosi.pop_front();
        chk(sb_shift == e, {cur_tag, " mosi byte"}, sb_shift, e);
      end
      sb_bit = 0; sb_pos++;
    end
  end
  always @(negedge spi_sclk) if (!spi_cs_n) begin
    logic [7:0] c;
    c = pat(sb_pos);
    spi_miso = c[7 - sb_bit];
  end

  // read-data monitor
  always @(negedge clk) if (rst_n && rd_valid) begin
    if (exp_rd.size() == 0) chk(1'b0, {cur_tag, " extra read byte"}, rd_data, 0);
    else begin
      logic [7:0] e;
      e = exp_rd.pop_front();
      chk(rd_data == e, {cur_tag, " read byte"}, rd_data, e);
    end
  end

  // write-stream feeder
  always @(negedge clk) begin
    if (wr_pend) void'(wr_q.pop_front());
    wr_valid = wr_q.size() > 0;
    wr_data = wr_valid ? wr_q[0] : 8'h00;
    wr_pend = wr_valid && wr_ready;
  end

  task automatic issue(input string tag, input logic [2:0] k, input logic [7:0] op,
                       input logic [15:0] a, input int n, input bit feed);
    int hl;
    bit rd;
    cur_tag = tag;
    rd = (k == 3'd1) || (k == 3'd2) || (k == 3'd5);
    case (k)
      3'd1: begin exp_mosi.push_back(op); exp_mosi.push_back(8'h00); hl = 2; end
      3'd2: begin exp_mosi.push_back(8'h1D); exp_mosi.push_back(a[15:8]); exp_mosi.push_back(a[7:0]);
                  exp_mosi.push_back(8'h00); hl = 4; n = 1; end
      3'd3: begin exp_mosi.push_back(8'h0D); exp_mosi.push_back(a[15:8]); exp_mosi.push_back(a[7:0]);
                  hl = 3; n = 1; end
      3'd4: begin if (a[15]) m_ptr = a[7:0];
                  exp_mosi.push_back(8'h0E); exp_mosi.push_back(m_ptr); hl = 2;
                  m_ptr = m_ptr + 8'(n); end
      3'd5: begin exp_mosi.push_back(8'h1E); exp_mosi.push_back(a[7:0]); exp_mosi.push_back(8'h00); hl = 3; end
      default: begin exp_mosi.push_back(op); hl = 1; end
    endcase
    for (int i = 0; i < n; i++) begin
      if (rd) begin
        exp_mosi.push_back(8'h00);
        exp_rd.push_back(pat(hl + i));
      end else begin
        exp_mosi.push_back(pay[i]);
        if (feed) wr_q.push_back(pay[i]);
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_opcode = op; req_addr = a; req_count = CW'(n);
    forever begin
      if (req_ready) begin
        @(negedge clk);
        req_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
    chk(req_ready == 1'b0, {tag, " ready low while busy R1"}, req_ready, 0);
  endtask

  task automatic wait_done(output bit to);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done == 1'b1, {cur_tag, " done pulse R4"}, done, 1);
    chk(spi_cs_n == 1'b1, {cur_tag, " cs released R4"}, spi_cs_n, 1);
    to = timeout;
    @(negedge clk);
    chk(exp_mosi.size() == 0, {cur_tag, " frame length"}, exp_mosi.size(), 0);
    chk(exp_rd.size() == 0, {cur_tag, " read count"}, exp_rd.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit to;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(spi_cs_n == 1'b1, "R1 reset cs", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R3 reset sclk", spi_sclk, 0);
    chk(tx_ptr == 8'h00, "R1 reset ptr", tx_ptr, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    pay = '{8'h01};
    issue("R5 opcode write", 3'd0, 8'h8A, 16'h0, 1, 1'b1);
    repeat (4) @(negedge clk);
    chk(spi_cs_n == 1'b0, "R4 cs low mid frame", spi_cs_n, 0);
    wait_done(to);
    chk(to == 1'b0, "R12 no timeout", to, 0);

    issue("R5 zero count", 3'd0, 8'h84, 16'h0, 0, 1'b1);
    wait_done(to);

    issue("R6 opcode read", 3'd1, 8'h12, 16'h0, 2, 1'b1);
    wait_done(to);

    issue("R7 register read", 3'd2, 8'h00, 16'h0740, 5, 1'b1);
    wait_done(to);

    pay = '{8'h96};
    issue("R8 register write", 3'd3, 8'h00, 16'h08AC, 7, 1'b1);
    wait_done(to);

    pay = '{8'h11, 8'h22, 8'h33};
    issue("R9 buffer write reload", 3'd4, 8'h00, 16'h80FE, 3, 1'b1);
    wait_done(to);
    chk(tx_ptr == 8'h01, "R9 pointer wrap", tx_ptr, 8'h01);
    pay = '{8'h44, 8'h55};
    issue("R9 buffer write continue", 3'd4, 8'h00, 16'h0000, 2, 1'b1);
    wait_done(to);
    chk(tx_ptr == 8'h03, "R9 pointer advance", tx_ptr, 8'h03);

    issue("R10 buffer read", 3'd5, 8'h00, 16'h0010, 3, 1'b1);
    wait_done(to);

    pay = '{8'hA5};
    issue("R11 stream stall", 3'd3, 8'h00, 16'h1234, 1, 1'b0);
    repeat (120) @(negedge clk);
    chk(spi_sclk == 1'b0, "R11 sclk frozen", spi_sclk, 0);
    chk(spi_cs_n == 1'b0, "R11 cs held", spi_cs_n, 0);
    chk(exp_mosi.size() == 1, "R11 header only sent", exp_mosi.size(), 1);
    wr_q.push_back(8'hA5);
    wait_done(to);

    radio_busy = 1'b1;
    issue("R2 short busy", 3'd0, 8'h80, 16'h0, 0, 1'b1);
    repeat (30) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R2 cs waits on busy", spi_cs_n, 1);
    radio_busy = 1'b0;
    wait_done(to);
    chk(to == 1'b0, "R12 busy cleared no timeout", to, 0);

    radio_busy = 1'b1;
    issue("R2 stuck busy", 3'd1, 8'hC0, 16'h0, 1, 1'b1);
    repeat (50) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R2 cs high before limit", spi_cs_n, 1);
    wait_done(to);
    chk(to == 1'b1, "R12 timeout flagged", to, 1);
    radio_busy = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule